// File: doc/BRIEF.md
# Triple Down-Counter Timer Bank

Three independent 16-bit down-counting timers sit behind one byte-wide register bus. Each timer has a configuration byte and two data bytes. The two data bytes hold the low and high halves of a reload value. Writing the configuration byte with its start bit set loads the counter from the reload value. The counter then steps down by one on each tick of its chosen tick enable until it reaches zero.

At zero, a continuous timer reloads on the next tick. A one-shot timer instead clears its own start bit and stops. The tick enable is one of two things:
- every system clock, or
- a slow-tick strobe supplied from outside.

All tick sources are single-cycle strobes in the one system clock domain.

Only timer 0 drives a terminal-count output. It is high while timer 0 rests at zero, which lasts exactly one tick. Timer 1 has two extra features:
- A sense-mode input can force it onto a third, prescaled tick strobe.
- Its start bit is exported for an external sensing block.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0, and `tc_o` and `sense_start_o` are low.
- R2: Timer n uses three bus addresses. Address 3n is the configuration byte: bit 0 is start, bit 1 is one-shot, bit 2 selects the clock (1 = every clock, 0 = slow tick), and the upper bits read 0. Address 3n+1 is the low reload byte and 3n+2 is the high reload byte. `bus_rdata_o` combinationally returns the addressed register. Addresses 9 and above read 0, and writes to them are ignored.
- R3: A configuration write with bit 0 set loads the counter from the reload value. This holds even when the timer is already running, so a restart always begins from the full reload value.
- R4: A running counter decrements only on its selected tick: every clock when the clock select is 1, or on a `slow_tick_i` strobe when it is 0. Between ticks it holds its value.
- R5: `tc_o` is high only while timer 0 runs and holds a count of zero, and it stays high for exactly one tick. In continuous mode with reload R, `tc_o` is low for R ticks and the output period is R+1 ticks.
- R6: In one-shot mode, when a tick arrives at count zero, the timer clears its start bit and stops. A configuration read then shows start = 0, and no further terminal-count pulse follows.
- R7: In continuous mode, a reload value of 0 keeps `tc_o` high on every tick.
- R8: While `sense_mode_i` is high, timer 1 ticks on `presc_tick_i` whatever its clock select says. While `sense_mode_i` is low, timer 1 follows its clock select.
- R9: `sense_start_o` equals timer 1's start bit.
- R10: A write to a data byte does not change a running count. The new value is used at the next load, which is either a start write or a continuous-mode reload.
- R11: A configuration write with bit 0 clear stops the timer, and `tc_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| slow_tick_i | input | 1 | Slow tick strobe |
| presc_tick_i | input | 1 | Prescaled tick strobe for timer 1 in sense mode |
| sense_mode_i | input | 1 | Forces timer 1 onto the prescaled tick |
| tc_o | output | 1 | Timer 0 terminal count |
| sense_start_o | output | 1 | Timer 1 start state |

## Verification
The hardest case to reach from the ports is the sense-mode override. Timer 1 has no count output, so its tick source can only be seen through the moment its one-shot start bit falls. The stimulus runs timer 1 as a one-shot with a short reload and the clock select set to every clock. It then holds `presc_tick_i` low for several cycles and requires `sense_start_o` to stay high. Next it supplies exactly two prescaled strobes and requires the fall. Last it repeats the run with the mode low, where the fall must come after two clocks. A random phase then mixes bus writes, both tick strobes and mode changes, and compares every cycle against a model in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int CFG_W    = 3;
  localparam int START_B  = 0;
  localparam int OS_B     = 1;
  localparam int CS_B     = 2;
  localparam int REGS_PER = 3;

  typedef struct packed {
    logic clksel;
    logic one_shot;
    logic start;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int N_TMR = 3,
  parameter int AW    = 4,
  parameter int DW    = BYTE_W,
  localparam int CW   = 2 * DW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic [N_TMR-1:0]              hw_clr_i,
  output logic [DW-1:0]                 rdata_o,
  output tmr_cfg_t [N_TMR-1:0]          cfg_o,
  output logic [N_TMR-1:0][CW-1:0]      reload_o,
  output logic [N_TMR-1:0]              load_o
);

  tmr_cfg_t [N_TMR-1:0]         cfg_q;
  logic [N_TMR-1:0][DW-1:0]     lo_q, hi_q;
  logic [N_TMR-1:0]             cfg_sel, lo_sel, hi_sel;

  for (genvar i = 0; i < N_TMR; i++) begin : g_reg
    localparam logic [AW-1:0] BASE = AW'(REGS_PER * i);

    assign cfg_sel[i] = we_i && (addr_i == BASE);
    assign lo_sel[i]  = we_i && (addr_i == BASE + AW'(1));
    assign hi_sel[i]  = we_i && (addr_i == BASE + AW'(2));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
      end else begin
        if (cfg_sel[i])       cfg_q[i] <= tmr_cfg_t'(wdata_i[CFG_W-1:0]);
        else if (hw_clr_i[i]) cfg_q[i].start <= 1'b0;
        if (lo_sel[i]) lo_q[i] <= wdata_i;
        if (hi_sel[i]) hi_q[i] <= wdata_i;
      end
    end

    assign reload_o[i] = {hi_q[i], lo_q[i]};
    assign load_o[i]   = cfg_sel[i] && wdata_i[START_B];

    AST_HW_CLR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_clr_i[i] && !cfg_sel[i]) |=> !cfg_o[i].start); // R6
    AST_LOAD_SETS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[i] |=> cfg_o[i].start); // R3
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (addr_i == AW'(REGS_PER * i))     rdata_o = {{(DW-CFG_W){1'b0}}, cfg_q[i]};
      if (addr_i == AW'(REGS_PER * i + 1)) rdata_o = lo_q[i];
      if (addr_i == AW'(REGS_PER * i + 2)) rdata_o = hi_q[i];
    end
  end

endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_TMR     = 3,
  parameter int SENSE_IDX = 1
) (
  input  logic             slow_tick_i,
  input  logic             presc_tick_i,
  input  logic             sense_mode_i,
  input  logic [N_TMR-1:0] clksel_i,
  output logic [N_TMR-1:0] tick_o
);

  for (genvar i = 0; i < N_TMR; i++) begin : g_sel
    if (i == SENSE_IDX) begin : g_ovr
      assign tick_o[i] = sense_mode_i ? presc_tick_i
                                      : (clksel_i[i] | slow_tick_i);
    end else begin : g_std
      assign tick_o[i] = clksel_i[i] | slow_tick_i;
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CW     = 16,
  parameter bit HAS_TC = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic          one_shot_i,
  input  logic          tick_i,
  input  logic [CW-1:0] reload_i,
  output logic          tc_o,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic          at_zero, step;

  assign at_zero = (cnt_q == '0);
  assign step    = run_i && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload_i;
    end else if (step) begin
      if (!at_zero)         cnt_q <= cnt_q - 1'b1;
      else if (!one_shot_i) cnt_q <= reload_i;
    end
  end

  assign done_o = step && at_zero && one_shot_i;

  if (HAS_TC) begin : g_tc
    assign tc_o = run_i && at_zero;
  end else begin : g_no_tc
    assign tc_o = 1'b0;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(reload_i))); // R3
  AST_DEC_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step) |=> $stable(cnt_q)); // R4
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load_i && at_zero && !one_shot_i) |=> (cnt_q == $past(reload_i))); // R5

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR     = 3,
  parameter int AW        = 4,
  parameter int DW        = BYTE_W,
  parameter int TC_IDX    = 0,
  parameter int SENSE_IDX = 1,
  localparam int CW       = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          slow_tick_i,
  input  logic          presc_tick_i,
  input  logic          sense_mode_i,
  output logic          tc_o,
  output logic          sense_start_o
);

  tmr_cfg_t [N_TMR-1:0]     cfg;
  logic [N_TMR-1:0][CW-1:0] reload;
  logic [N_TMR-1:0]         load, done, tick, clksel, tc_vec;

  tmr_regs #(.N_TMR(N_TMR), .AW(AW), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .hw_clr_i (done),
    .rdata_o  (bus_rdata_o),
    .cfg_o    (cfg),
    .reload_o (reload),
    .load_o   (load)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_cs
    assign clksel[i] = cfg[i].clksel;
  end

  tmr_tick_sel #(.N_TMR(N_TMR), .SENSE_IDX(SENSE_IDX)) u_tick (
    .slow_tick_i  (slow_tick_i),
    .presc_tick_i (presc_tick_i),
    .sense_mode_i (sense_mode_i),
    .clksel_i     (clksel),
    .tick_o       (tick)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    tmr_core #(.CW(CW), .HAS_TC(i == TC_IDX)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[i]),
      .run_i      (cfg[i].start),
      .one_shot_i (cfg[i].one_shot),
      .tick_i     (tick[i]),
      .reload_i   (reload[i]),
      .tc_o       (tc_vec[i]),
      .done_o     (done[i])
    );
  end

  assign tc_o          = |tc_vec;
  assign sense_start_o = cfg[SENSE_IDX].start;

  AST_TC_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && tick[TC_IDX] && !bus_we_i &&
     (cfg[TC_IDX].one_shot || reload[TC_IDX] != '0)) |=> !tc_o); // R5
  AST_TC_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cfg[TC_IDX].start); // R11
  AST_SENSE_FALL_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sense_start_o) && !$past(bus_we_i)) |-> $past(cfg[SENSE_IDX].one_shot)); // R6

endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       slow = 1'b0, presc = 1'b0, sense = 1'b0;
  logic       tc, s_start;
  int         errors = 0, checks = 0;
  bit         done_flag = 1'b0;

  always #5 clk = ~clk;

  tmr_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .slow_tick_i(slow),
    .presc_tick_i(presc), .sense_mode_i(sense), .tc_o(tc),
    .sense_start_o(s_start)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt [3];
  bit          m_st [3], m_os [3], m_cs [3];
  logic [7:0]  m_lo [3], m_hi [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = '0; m_st[i] = 0; m_os[i] = 0; m_cs[i] = 0;
        m_lo[i] = '0; m_hi[i] = '0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit tk;
        tk = (i == 1 && sense) ? presc : (m_cs[i] ? 1'b1 : slow);
        if (we && addr == 4'(3*i)) begin
          m_st[i] = wdata[0]; m_os[i] = wdata[1]; m_cs[i] = wdata[2];
          if (wdata[0]) m_cnt[i] = {m_hi[i], m_lo[i]};
        end else if (m_st[i] && tk) begin
          if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
          else if (m_os[i]) m_st[i] = 0;
          else m_cnt[i] = {m_hi[i], m_lo[i]};
        end
        if (we && addr == 4'(3*i+1)) m_lo[i] = wdata;
        if (we && addr == 4'(3*i+2)) m_hi[i] = wdata;
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    for (int i = 0; i < 3; i++) begin
      if (a == 4'(3*i))   return {5'b0, m_cs[i], m_os[i], m_st[i]};
      if (a == 4'(3*i+1)) return m_lo[i];
      if (a == 4'(3*i+2)) return m_hi[i];
    end
    return 8'h00;
  endfunction

  function automatic bit exp_tc();
    return m_st[0] && (m_cnt[0] == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next edge's inputs
  task automatic cyc(input bit w, input logic [3:0] a, input logic [7:0] d,
                     input bit s, input bit p, input string tag);
    @(negedge clk);
    chk(tc == exp_tc(), {"R5 tc ", tag}, tc, exp_tc());
    chk(s_start == m_st[1], {"R9 sense_start ", tag}, s_start, m_st[1]);
    chk(rdata == exp_rd(addr), {"R2 rdata ", tag}, rdata, exp_rd(addr));
    we = w; addr = a; wdata = d; slow = s; presc = p;
  endtask

  task automatic idle(input string tag);
    cyc(0, addr, 8'h00, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      addr = 4'(a); #1;
      chk(rdata == 8'h00, "R1 reset readback", rdata, 0);
    end
    chk(tc == 0, "R1 reset tc", tc, 0);
    chk(s_start == 0, "R1 reset sense_start", s_start, 0);
    rst_n = 1'b1;

    // R5: continuous reload 5 on every clock -> period 6, one-tick high
    cyc(1, 4'd1, 8'd5, 0, 0, "setup");
    cyc(1, 4'd2, 8'd0, 0, 0, "setup");
    cyc(1, 4'd0, 8'h05, 0, 0, "start");
    for (int k = 0; k < 14; k++) begin
      idle("R5");
      chk(tc == (k % 6 == 5), "R5 period", tc, (k % 6 == 5));
    end

    // R10: data change mid-run only affects next load
    cyc(1, 4'd1, 8'd2, 0, 0, "R10");
    for (int k = 0; k < 12; k++) idle("R10");

    // R3: restart mid-count begins from reload
    cyc(1, 4'd1, 8'd4, 0, 0, "R3");
    idle("R3");
    cyc(1, 4'd0, 8'h05, 0, 0, "R3 restart");
    for (int k = 0; k < 6; k++) begin
      idle("R3");
      chk(tc == (k == 4), "R3 restart count", tc, (k == 4));
    end

    // R11: stop
    cyc(1, 4'd0, 8'h04, 0, 0, "R11");
    for (int k = 0; k < 8; k++) begin
      idle("R11");
      chk(tc == 0, "R11 stopped tc", tc, 0);
    end

    // R6: one-shot reload 2
    cyc(1, 4'd1, 8'd2, 0, 0, "R6");
    cyc(1, 4'd0, 8'h07, 0, 0, "R6 start");
    for (int k = 0; k < 8; k++) begin
      idle("R6");
      chk(tc == (k == 2), "R6 single pulse", tc, (k == 2));
    end
    cyc(0, 4'd0, 8'h00, 0, 0, "R6");
    #1 chk(rdata == 8'h06, "R6 start cleared readback", rdata, 8'h06);

    // R7: continuous reload 0
    cyc(1, 4'd1, 8'd0, 0, 0, "R7");
    cyc(1, 4'd0, 8'h05, 0, 0, "R7 start");
    for (int k = 0; k < 5; k++) begin
      idle("R7");
      chk(tc == 1, "R7 constant tc", tc, 1);
    end

    // R4: slow tick, reload 3
    cyc(1, 4'd1, 8'd3, 0, 0, "R4");
    cyc(1, 4'd0, 8'h01, 0, 0, "R4 start");
    for (int k = 0; k < 10; k++) idle("R4 no tick");
    chk(tc == 0, "R4 held without tick", tc, 0);
    for (int k = 0; k < 30; k++) cyc(0, 4'd0, 8'h00, (k % 3 == 0), 0, "R4 slow");

    // R8: sense mode overrides timer 1 clock select
    cyc(1, 4'd4, 8'd1, 0, 0, "R8");
    cyc(1, 4'd5, 8'd0, 0, 0, "R8");
    sense = 1'b1;
    cyc(1, 4'd3, 8'h07, 0, 0, "R8 start");
    for (int k = 0; k < 6; k++) begin
      idle("R8 no presc");
      chk(s_start == 1, "R8 sense ignores clksel", s_start, 1);
    end
    cyc(0, 4'd3, 8'h00, 0, 1, "R8");
    cyc(0, 4'd3, 8'h00, 0, 1, "R8");
    idle("R8");
    chk(s_start == 0, "R8 presc ticks end one-shot", s_start, 0);
    sense = 1'b0;
    cyc(1, 4'd3, 8'h07, 0, 0, "R8 low");
    for (int k = 0; k < 3; k++) begin
      idle("R8 low");
      chk(s_start == (k < 2), "R8 follows clksel", s_start, (k < 2));
    end

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      bit w; logic [3:0] a; logic [7:0] d;
      w = ($urandom % 6) == 0;
      a = 4'($urandom % 12);
      d = 8'($urandom);
      if (a == 4'd2 || a == 4'd5 || a == 4'd8) d = ($urandom % 8 == 0) ? d : 8'h00;
      else if (a == 4'd1 || a == 4'd4 || a == 4'd7) d = d & 8'h0f;
      if (($urandom % 64) == 0) sense = ~sense;
      cyc(w, a, d, ($urandom % 4) == 0, ($urandom % 3) == 0, "random");
    end
    idle("final");
    finish_run();
  end
endmodule